// File: doc/BRIEF.md
# Bit-Field Extract, Deposit and Funnel-Shift Unit

This block is a 64-bit datapath slice that covers the bit-manipulation operations of an integer pipeline. It performs left shifts, logical and arithmetic right shifts, and signed or unsigned extraction of a field. It can deposit the low bits of one operand into a field of a background word. It can also take a window out of the 128-bit concatenation of its two operands, which gives a funnel shift, and a rotate when both operands are equal.

The operation, two data operands, a field position and a length or shift amount are presented together with a valid strobe. The result is computed combinationally and captured in an output register on the next rising clock edge. A flag marks that cycle. The result is held until the next valid operation.

Top module: `bitfield_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` is 0 and `result` is 0.
- R2: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. `result` changes only after an accepted operation, and inputs presented with `in_valid` low leave it unchanged.
- R3: Opcode 0 shifts `src_a` left by `amt` and fills with zeros. An `amt` of 64 or more gives 0.
- R4: Opcode 1 shifts `src_a` right by `amt` and fills with zeros. An `amt` of 64 or more gives 0.
- R5: Opcode 2 shifts `src_a` right by `amt` and fills with copies of bit 63. An `amt` of 64 or more gives 64 copies of bit 63.
- R6: Opcode 3 takes the field of `src_a` that starts at bit `pos` and is `amt` bits long. It moves the field to bit 0 and fills the bits above it with the top bit of the field.
- R7: Opcode 4 extracts the same field as opcode 3 but fills the bits above it with zeros.
- R8: Opcode 5 writes the low bits of `src_a` into the field at `pos`/`amt` and takes every bit outside the field from `src_b`.
- R9: Opcode 6 returns the low 64 bits of the 128-bit value {`src_a`,`src_b`} shifted right by `amt`, for `amt` from 0 to 127. An `amt` of 64 returns `src_a`.
- R10: With opcode 6 and `src_a` equal to `src_b`, the result is `src_a` rotated right by `amt` modulo 64.
- R11: For opcodes 3, 4 and 5, a field that would reach past bit 63 ends at bit 63.
- R12: For opcodes 3, 4 and 5, a length of 0 acts as 1 and a length of 64 or more acts as 64.
- R13: Opcode 7 produces a result of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 3 | Operation code (0 to 7, see requirements) |
| src_a | input | 64 | First operand; upper half of the pair |
| src_b | input | 64 | Second operand; background word; lower half of the pair |
| pos | input | 6 | Field start bit |
| amt | input | 7 | Field length or shift amount |
| out_valid | output | 1 | Result-register update flag |
| result | output | 64 | Registered result |

## Verification
The bench builds the unit at its default 64-bit width. At that width the seven-bit amount can exceed the word size, so the saturated shift counts and the funnel counts from 64 to 127 can be reached. Fields can also start near bit 63, which brings the clipping and zero-length cases within reach. Sign-fill cases use values whose field top bit is set and values where it is clear. Rotate is checked with identical pair inputs, and the hold behaviour is checked by changing the inputs while the strobe is low.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

    typedef enum logic [2:0] {
        BFU_SHL    = 3'd0,
        BFU_SHR_L  = 3'd1,
        BFU_SHR_A  = 3'd2,
        BFU_EXT_S  = 3'd3,
        BFU_EXT_U  = 3'd4,
        BFU_DEP    = 3'd5,
        BFU_FUNNEL = 3'd6,
        BFU_NONE   = 3'd7
    } bfu_op_e;

    // Smaller of two unsigned widths, in 32-bit arithmetic
    function automatic int unsigned bfu_min(input int unsigned x, input int unsigned y);
        return (x < y) ? x : y;
    endfunction

endpackage

// File: rtl/bfu_maskgen.sv
module bfu_maskgen #(
    parameter int DATA_W = 64,
    parameter int SHW    = $clog2(DATA_W),
    parameter int CNT_W  = SHW + 1
) (
    input  logic [SHW-1:0]    pos,
    input  logic [CNT_W-1:0]  len,
    output logic [DATA_W-1:0] low_mask,
    output logic [DATA_W-1:0] field_mask,
    output logic [SHW-1:0]    top_idx
);
    localparam int WW = CNT_W + 1;
    localparam logic [WW-1:0] FULL = WW'(DATA_W);
    localparam logic [WW-1:0] ONE  = WW'(1);

    logic [WW-1:0] req_w;
    logic [WW-1:0] room;
    logic [WW-1:0] eff_w;
    logic [WW-1:0] top_full;

    always_comb begin
        // zero length behaves as one bit, oversize lengths saturate
        if (len == '0)
            req_w = ONE;
        else if ({1'b0, len} > FULL)
            req_w = FULL;
        else
            req_w = {1'b0, len};
        room  = FULL - {{(WW-SHW){1'b0}}, pos};
        eff_w = (req_w < room) ? req_w : room;
        if (eff_w >= FULL)
            low_mask = '1;
        else
            low_mask = (DATA_W'(1) << eff_w) - DATA_W'(1);
        field_mask = low_mask << pos;
        top_full   = {{(WW-SHW){1'b0}}, pos} + eff_w - ONE;
        top_idx    = top_full[SHW-1:0];
    end

endmodule

// File: rtl/bfu_shift.sv
module bfu_shift #(
    parameter int DATA_W = 64,
    parameter int SHW    = $clog2(DATA_W),
    parameter int CNT_W  = SHW + 1
) (
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [CNT_W-1:0]  amt,
    output logic [DATA_W-1:0] shl_res,
    output logic [DATA_W-1:0] shr_l_res,
    output logic [DATA_W-1:0] shr_a_res,
    output logic [DATA_W-1:0] funnel_res
);
    localparam logic [CNT_W-1:0] AMT_FULL = CNT_W'(DATA_W);

    logic              too_far;
    logic [2*DATA_W-1:0] pair_sh;

    always_comb begin
        too_far = (amt >= AMT_FULL);
        if (too_far) begin
            shl_res   = '0;
            shr_l_res = '0;
            shr_a_res = {DATA_W{src_a[DATA_W-1]}};
        end else begin
            shl_res   = src_a << amt;
            shr_l_res = src_a >> amt;
            shr_a_res = DATA_W'($signed(src_a) >>> amt);
        end
        pair_sh    = {src_a, src_b} >> amt;
        funnel_res = pair_sh[DATA_W-1:0];
    end

endmodule

// File: rtl/bfu_field.sv
module bfu_field #(
    parameter int DATA_W = 64,
    parameter int SHW    = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [SHW-1:0]    pos,
    input  logic [DATA_W-1:0] low_mask,
    input  logic [DATA_W-1:0] field_mask,
    input  logic [SHW-1:0]    top_idx,
    output logic [DATA_W-1:0] ext_s_res,
    output logic [DATA_W-1:0] ext_u_res,
    output logic [DATA_W-1:0] dep_res
);
    logic [DATA_W-1:0] aligned;
    logic              fill_bit;

    always_comb begin
        aligned   = (src_a >> pos) & low_mask;
        fill_bit  = src_a[top_idx];
        ext_u_res = aligned;
        ext_s_res = aligned | (fill_bit ? ~low_mask : '0);
        dep_res   = ((src_a << pos) & field_mask) | (src_b & ~field_mask);
    end

endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit #(
    parameter int DATA_W = 64,
    parameter int SHW    = $clog2(DATA_W),
    parameter int CNT_W  = SHW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [SHW-1:0]    pos,
    input  logic [CNT_W-1:0]  amt,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    import bfu_pkg::*;

    bfu_op_e           op_sel;
    logic [DATA_W-1:0] low_mask, field_mask;
    logic [SHW-1:0]    top_idx;
    logic [DATA_W-1:0] shl_res, shr_l_res, shr_a_res, funnel_res;
    logic [DATA_W-1:0] ext_s_res, ext_u_res, dep_res;
    logic [DATA_W-1:0] next_res;
    logic [DATA_W-1:0] res_q;
    logic              vld_q;

    assign op_sel = bfu_op_e'(op);

    bfu_maskgen #(.DATA_W(DATA_W), .SHW(SHW), .CNT_W(CNT_W)) u_mask (
        .pos        (pos),
        .len        (amt),
        .low_mask   (low_mask),
        .field_mask (field_mask),
        .top_idx    (top_idx)
    );

    bfu_shift #(.DATA_W(DATA_W), .SHW(SHW), .CNT_W(CNT_W)) u_shift (
        .src_a      (src_a),
        .src_b      (src_b),
        .amt        (amt),
        .shl_res    (shl_res),
        .shr_l_res  (shr_l_res),
        .shr_a_res  (shr_a_res),
        .funnel_res (funnel_res)
    );

    bfu_field #(.DATA_W(DATA_W), .SHW(SHW)) u_field (
        .src_a      (src_a),
        .src_b      (src_b),
        .pos        (pos),
        .low_mask   (low_mask),
        .field_mask (field_mask),
        .top_idx    (top_idx),
        .ext_s_res  (ext_s_res),
        .ext_u_res  (ext_u_res),
        .dep_res    (dep_res)
    );

    always_comb begin
        case (op_sel)
            BFU_SHL:    next_res = shl_res;
            BFU_SHR_L:  next_res = shr_l_res;
            BFU_SHR_A:  next_res = shr_a_res;
            BFU_EXT_S:  next_res = ext_s_res;
            BFU_EXT_U:  next_res = ext_u_res;
            BFU_DEP:    next_res = dep_res;
            BFU_FUNNEL: next_res = funnel_res;
            default:    next_res = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= in_valid;
            if (in_valid)
                res_q <= next_res;
        end
    end

    assign out_valid = vld_q;
    assign result    = res_q;

endmodule

// File: rtl/bitfield_unit_chk.sv
module bitfield_unit_chk #(
    parameter int DATA_W = 64,
    parameter int SHW    = $clog2(DATA_W),
    parameter int CNT_W  = SHW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [CNT_W-1:0]  amt,
    input  logic              out_valid,
    input  logic [DATA_W-1:0] result
);
    localparam logic [CNT_W-1:0] AMT_FULL = CNT_W'(DATA_W);

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid)));

    // R2
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_valid)) |-> $stable(result));

    // R3
    shl_zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(op) == 3'd0 && $past(amt) < AMT_FULL)
        |-> ((result & ((DATA_W'(1) << $past(amt)) - DATA_W'(1))) == '0));

    // R4
    big_count_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ($past(op) == 3'd0 || $past(op) == 3'd1) && $past(amt) >= AMT_FULL)
        |-> (result == '0));

    // R7
    ext_u_top_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(op) == 3'd4 && $past(amt) < AMT_FULL)
        |-> (result[DATA_W-1] == 1'b0));

    // R10
    rotate_popcount_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(op) == 3'd6 && $past(src_a) == $past(src_b))
        |-> ($countones(result) == $countones($past(src_a))));

    // R13
    null_op_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(op) == 3'd7) |-> (result == '0));

endmodule

bind bitfield_unit bitfield_unit_chk #(.DATA_W(DATA_W), .SHW(SHW), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op        (op),
    .src_a     (src_a),
    .src_b     (src_b),
    .amt       (amt),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/bitfield_unit_test.sv
`timescale 1ns/1ps
module bitfield_unit_test;

    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  op;
        logic [63:0] a;
        logic [63:0] b;
        logic [5:0]  pos;
        logic [6:0]  amt;
        logic [63:0] exp;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{4'd3,  3'd0, 64'h1, 64'h0, 6'd0, 7'd4, 64'h10},                                   // R3
        '{4'd3,  3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 6'd0, 7'd64, 64'h0},                 // R3
        '{4'd4,  3'd1, 64'h8000_0000_0000_0000, 64'h0, 6'd0, 7'd63, 64'h1},                 // R4
        '{4'd4,  3'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 6'd0, 7'd100, 64'h0},                // R4
        '{4'd5,  3'd2, 64'h8000_0000_0000_0000, 64'h0, 6'd0, 7'd4, 64'hF800_0000_0000_0000}, // R5
        '{4'd5,  3'd2, 64'h8000_0000_0000_0000, 64'h0, 6'd0, 7'd70, 64'hFFFF_FFFF_FFFF_FFFF},// R5
        '{4'd5,  3'd2, 64'h7000_0000_0000_0000, 64'h0, 6'd0, 7'd4, 64'h0700_0000_0000_0000}, // R5
        '{4'd6,  3'd3, 64'h0F00, 64'h0, 6'd8, 7'd4, 64'hFFFF_FFFF_FFFF_FFFF},                // R6
        '{4'd6,  3'd3, 64'h0700, 64'h0, 6'd8, 7'd4, 64'h7},                                  // R6
        '{4'd7,  3'd4, 64'h0F00, 64'h0, 6'd8, 7'd4, 64'hF},                                  // R7
        '{4'd11, 3'd4, 64'hABCD_0000_0000_0000, 64'h0, 6'd48, 7'd40, 64'hABCD},              // R11
        '{4'd11, 3'd3, 64'hABCD_0000_0000_0000, 64'h0, 6'd48, 7'd40, 64'hFFFF_FFFF_FFFF_ABCD},// R11
        '{4'd12, 3'd4, 64'h20, 64'h0, 6'd5, 7'd0, 64'h1},                                    // R12
        '{4'd12, 3'd3, 64'h20, 64'h0, 6'd5, 7'd0, 64'hFFFF_FFFF_FFFF_FFFF},                  // R12
        '{4'd8,  3'd5, 64'h5, 64'hFFFF_FFFF_FFFF_FFFF, 6'd4, 7'd4, 64'hFFFF_FFFF_FFFF_FF5F}, // R8
        '{4'd11, 3'd5, 64'hFF, 64'h0, 6'd60, 7'd8, 64'hF000_0000_0000_0000},                 // R11
        '{4'd9,  3'd6, 64'h1122_3344_5566_7788, 64'h99AA_BBCC_DDEE_FF00, 6'd0, 7'd8,
                 64'h8899_AABB_CCDD_EEFF},                                                   // R9
        '{4'd9,  3'd6, 64'h1122_3344_5566_7788, 64'h99AA_BBCC_DDEE_FF00, 6'd0, 7'd64,
                 64'h1122_3344_5566_7788},                                                   // R9
        '{4'd9,  3'd6, 64'h1122_3344_5566_7788, 64'h99AA_BBCC_DDEE_FF00, 6'd0, 7'd0,
                 64'h99AA_BBCC_DDEE_FF00},                                                   // R9
        '{4'd10, 3'd6, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 6'd0, 7'd4,
                 64'hF012_3456_789A_BCDE},                                                   // R10
        '{4'd13, 3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 6'd3, 7'd3, 64'h0}, // R13
        '{4'd12, 3'd4, 64'h8000_0000_0000_0001, 64'h0, 6'd0, 7'd64, 64'h8000_0000_0000_0001},// R12
        '{4'd12, 3'd5, 64'h1, 64'h0, 6'd63, 7'd0, 64'h8000_0000_0000_0000}                   // R12
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [5:0]  pos = '0;
    logic [6:0]  amt = '0;
    logic        out_valid;
    logic [63:0] result;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bitfield_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .src_a(src_a), .src_b(src_b), .pos(pos), .amt(amt),
        .out_valid(out_valid), .result(result)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        op = v.op; src_a = v.a; src_b = v.b; pos = v.pos; amt = v.amt;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [63:0] held;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 out_valid in reset", {63'd0, out_valid}, 64'd0);
        check("R1 result in reset", result, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 out_valid after reset", {63'd0, out_valid}, 64'd0);

        // table walk, one operation at a time
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            check($sformatf("R%0d vec%0d", VECS[i].req, i), result, VECS[i].exp);
            check("R2 out_valid raised", {63'd0, out_valid}, 64'd1);
        end

        // R2: strobe low, inputs change, result and flag hold
        held = result;
        @(negedge clk);
        drive(VECS[0]);
        @(negedge clk);
        drive(VECS[4]);
        @(negedge clk);
        check("R2 result held", result, held);
        check("R2 out_valid low", {63'd0, out_valid}, 64'd0);

        // R2: back-to-back operations, each result one cycle later
        drive(VECS[2]);
        in_valid = 1'b1;
        @(negedge clk);
        check("R2 stream first", result, VECS[2].exp);
        drive(VECS[9]);
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 stream second", result, VECS[9].exp);
        check("R2 stream valid", {63'd0, out_valid}, 64'd1);
        @(negedge clk);
        check("R2 stream valid drops", {63'd0, out_valid}, 64'd0);

        // R1: reset mid-run clears result
        rst = 1'b1;
        @(negedge clk);
        check("R1 result cleared", result, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        finish_run();
    end

endmodule